// File: doc/BRIEF.md
# Serial EEPROM Byte Writer with Ready Polling

This block is a two-wire bus master that stores one byte into a serial EEPROM. A one-cycle `go` pulse, along with a word address and a data byte, starts the operation. The block first holds the bus idle for one bit time. It then sends a start condition, a write control byte, the address byte, the data byte and a stop condition. The stop condition begins the memory's internal programming cycle.

The block does not wait out a fixed worst-case programming delay. Right after that stop, it sends a start and the write control byte again and looks at the ninth clock. While the memory is busy it does not acknowledge. The master then sends a stop and tries again. The first acknowledge ends the poll with a stop and a trailing idle gap, and `done` pulses. Two faults are reported: a missing acknowledge in the write frame, and a poll count that runs out. Both lines are open drain: the block only decides when to pull each line low.

States of the sequencer:
- IDLE waits for `go` and goes to LEAD_GAP.
- LEAD_GAP leads to W_START, W_START to W_CTRL, W_CTRL to W_ADDR, W_ADDR to W_DATA, and W_DATA to W_STOP. If any of the three byte states is not acknowledged, the sequencer goes straight to W_STOP and flags an error.
- From W_STOP the sequencer goes to P_START, or to TRAIL_GAP after an error.
- P_START leads to P_CTRL. An acknowledge leads to P_END_STOP. A refusal leads to P_RETRY_STOP and then back to P_START. A refusal on the last allowed attempt leads to P_END_STOP with the timeout flag set.
- P_END_STOP leads to TRAIL_GAP, and TRAIL_GAP leads back to IDLE.

The bit engine runs four commands: idle gap, start, stop and byte.

Top module: `ackpoll_writer`

## Requirements
- R1: After reset both lines are released (`scl_low`=0, `sda_low`=0), and `busy`, `done`, `err_nack` and `err_timeout` are all 0. Whenever `busy` is 0, both lines are released.
- R2: A `go` pulse while idle latches `addr` and `wdata` and raises `busy` on the next cycle. A `go` pulse while busy is ignored: it changes neither the transfer in flight nor the data written, and it starts no second transfer.
- R3: Before the first start and after the final stop, both lines stay released for at least one bit time (4×DIV clock cycles).
- R4: The write frame carries three bytes, MSB first, each followed by a ninth clock during which SDA is released. The bytes are the control byte 0xA0 (device code 1010, three zero bits, R/W=0), the address byte {4'b0000, addr} and `wdata`. A stop follows the third byte.
- R5: The SCL period within a byte is 4×DIV clock cycles. While SCL is released during a byte, SDA does not change.
- R6: After the write stop, each poll attempt is a start followed by control byte 0xA0. A refused attempt (SDA high on the ninth clock) is followed by a stop and then a new start.
- R7: An acknowledged poll is followed by a stop, the trailing idle gap and a `done` pulse, with both error flags 0.
- R8: If the control, address or data byte of the write frame is refused, the block sends a stop, skips polling, sets `err_nack` and pulses `done`. `err_nack` and `err_timeout` are never both 1.
- R9: After MAX_POLLS refused poll attempts, the block stops, sets `err_timeout` and pulses `done`. An acknowledge on attempt MAX_POLLS still counts as success.
- R10: `done` is high for exactly one cycle. The error flags keep their values until the next accepted `go` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, taken only while idle |
| addr | input | ADDR_W | Word address inside the memory |
| wdata | input | 8 | Byte to store |
| sda_in | input | 1 | Resolved level of the SDA line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_nack | output | 1 | Write frame was refused |
| err_timeout | output | 1 | Poll limit reached without an acknowledge |

## Verification
The ninth-clock sample of a poll and the retry-limit decision can fall on the same clock edge. The outcome then depends on which of the two wins. A bench memory model refuses a set number of polls after it accepts a write. Setting that number to MAX_POLLS−1 puts the acknowledge on the last allowed attempt, and success is expected. Setting it to MAX_POLLS puts a refusal there, and a timeout is expected. In both cases the bench also counts the poll attempts and the stop conditions seen on the bus.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

    typedef enum logic [1:0] {
        CMD_GAP,
        CMD_START,
        CMD_STOP,
        CMD_BYTE
    } bus_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LEAD_GAP,
        S_W_START,
        S_W_CTRL,
        S_W_ADDR,
        S_W_DATA,
        S_W_STOP,
        S_P_START,
        S_P_CTRL,
        S_P_RETRY_STOP,
        S_P_END_STOP,
        S_TRAIL_GAP
    } seq_state_e;

endpackage

// File: rtl/ackpoll_qtick.sv
module ackpoll_qtick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/ackpoll_bitengine.sv
module ackpoll_bitengine
    import ackpoll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  bus_cmd_e   cmd,
    input  logic [7:0] tx_byte,
    input  logic       sda_in,
    output logic       active,
    output logic       cmd_done,
    output logic       ack_ok,
    output logic       in_byte,
    output logic       scl_low,
    output logic       sda_low
);
    bus_cmd_e   cmd_q;
    logic       busy_q;
    logic [1:0] qtr_q;
    logic [3:0] bit_q;
    logic [7:0] sh_q;
    logic       ack_q;
    logic       done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_GAP;
            busy_q <= 1'b0;
            qtr_q  <= 2'd3;
            bit_q  <= 4'd0;
            sh_q   <= 8'h00;
            ack_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && cmd_valid) begin
                cmd_q  <= cmd;
                busy_q <= 1'b1;
                qtr_q  <= 2'd0;
                bit_q  <= 4'd0;
                sh_q   <= tx_byte;
                ack_q  <= 1'b0;
            end else if (busy_q && tick) begin
                if (qtr_q == 2'd1 && cmd_q == CMD_BYTE && bit_q == 4'd8) begin
                    ack_q <= !sda_in;
                end
                if (qtr_q == 2'd3) begin
                    if (cmd_q != CMD_BYTE || bit_q == 4'd8) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        qtr_q <= 2'd0;
                    end
                end else begin
                    qtr_q <= qtr_q + 1'b1;
                end
            end
        end
    end

    // Line levels follow the held command, so lines keep their last level between commands.
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (cmd_q)
            CMD_GAP: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
            CMD_START: begin
                scl_low = (qtr_q == 2'd3);
                sda_low = (qtr_q >= 2'd2);
            end
            CMD_STOP: begin
                scl_low = (qtr_q == 2'd0);
                sda_low = (qtr_q != 2'd3);
            end
            CMD_BYTE: begin
                scl_low = (qtr_q == 2'd0) || (qtr_q == 2'd3);
                sda_low = (bit_q < 4'd8) ? !sh_q[3'd7 - bit_q[2:0]] : 1'b0;
            end
        endcase
    end

    assign active   = busy_q;
    assign cmd_done = done_q;
    assign ack_ok   = ack_q;
    assign in_byte  = busy_q && (cmd_q == CMD_BYTE);
endmodule

// File: rtl/ackpoll_writer.sv
module ackpoll_writer
    import ackpoll_pkg::*;
#(
    parameter int          DIV       = 8,
    parameter int          MAX_POLLS = 64,
    parameter int          ADDR_W    = 4,
    parameter logic [3:0]  DEV_CODE  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low,
    output logic              busy,
    output logic              done,
    output logic              err_nack,
    output logic              err_timeout
);
    localparam int         PW       = $clog2(MAX_POLLS + 1);
    localparam int         PAD      = 8 - ADDR_W;
    localparam logic [7:0] CTRL_WR  = {DEV_CODE, 3'b000, 1'b0};
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    seq_state_e        state_q, state_d;
    logic              issued_q;
    logic [PW-1:0]     poll_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              err_nack_q, err_to_q, done_q;

    logic       tick, eng_active, eng_done, eng_ack, in_byte;
    logic       cmd_valid;
    bus_cmd_e   cmd_sel;
    logic [7:0] tx_sel;
    logic       accept;
    logic       poll_last;

    assign accept    = (state_q == S_IDLE) && go;
    assign poll_last = (poll_q == POLL_LAST);
    assign cmd_valid = (state_q != S_IDLE) && !issued_q;

    ackpoll_qtick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_active),
        .tick  (tick)
    );

    ackpoll_bitengine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd       (cmd_sel),
        .tx_byte   (tx_sel),
        .sda_in    (sda_in),
        .active    (eng_active),
        .cmd_done  (eng_done),
        .ack_ok    (eng_ack),
        .in_byte   (in_byte),
        .scl_low   (scl_low),
        .sda_low   (sda_low)
    );

    // Command chosen by the current state
    always_comb begin
        cmd_sel = CMD_GAP;
        tx_sel  = CTRL_WR;
        unique case (state_q)
            S_IDLE, S_LEAD_GAP, S_TRAIL_GAP: cmd_sel = CMD_GAP;
            S_W_START, S_P_START:            cmd_sel = CMD_START;
            S_W_CTRL, S_P_CTRL: begin
                cmd_sel = CMD_BYTE;
                tx_sel  = CTRL_WR;
            end
            S_W_ADDR: begin
                cmd_sel = CMD_BYTE;
                tx_sel  = {{PAD{1'b0}}, addr_q};
            end
            S_W_DATA: begin
                cmd_sel = CMD_BYTE;
                tx_sel  = data_q;
            end
            S_W_STOP, S_P_RETRY_STOP, S_P_END_STOP: cmd_sel = CMD_STOP;
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:         if (go) state_d = S_LEAD_GAP;
            S_LEAD_GAP:     if (eng_done) state_d = S_W_START;
            S_W_START:      if (eng_done) state_d = S_W_CTRL;
            S_W_CTRL:       if (eng_done) state_d = eng_ack ? S_W_ADDR : S_W_STOP;
            S_W_ADDR:       if (eng_done) state_d = eng_ack ? S_W_DATA : S_W_STOP;
            S_W_DATA:       if (eng_done) state_d = S_W_STOP;
            S_W_STOP:       if (eng_done) state_d = err_nack_q ? S_TRAIL_GAP : S_P_START;
            S_P_START:      if (eng_done) state_d = S_P_CTRL;
            S_P_CTRL: begin
                if (eng_done) begin
                    if (eng_ack || poll_last) state_d = S_P_END_STOP;
                    else                      state_d = S_P_RETRY_STOP;
                end
            end
            S_P_RETRY_STOP: if (eng_done) state_d = S_P_START;
            S_P_END_STOP:   if (eng_done) state_d = S_TRAIL_GAP;
            S_TRAIL_GAP:    if (eng_done) state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q   <= 1'b0;
            poll_q     <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            err_nack_q <= 1'b0;
            err_to_q   <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= (state_q == S_TRAIL_GAP) && eng_done;
            if (eng_done)       issued_q <= 1'b0;
            else if (cmd_valid) issued_q <= 1'b1;
            if (accept) begin
                addr_q     <= addr;
                data_q     <= wdata;
                poll_q     <= '0;
                err_nack_q <= 1'b0;
                err_to_q   <= 1'b0;
            end
            if (eng_done && !eng_ack &&
                (state_q == S_W_CTRL || state_q == S_W_ADDR || state_q == S_W_DATA)) begin
                err_nack_q <= 1'b1;
            end
            if (eng_done && !eng_ack && state_q == S_P_CTRL) begin
                if (poll_last) err_to_q <= 1'b1;
                else           poll_q   <= poll_q + 1'b1;
            end
        end
    end

    assign busy        = (state_q != S_IDLE);
    assign done        = done_q;
    assign err_nack    = err_nack_q;
    assign err_timeout = err_to_q;
endmodule

module ackpoll_checker (
    input logic clk,
    input logic rst_n,
    input logic go,
    input logic busy,
    input logic done,
    input logic err_nack,
    input logic err_timeout,
    input logic scl_low,
    input logic sda_low,
    input logic in_byte
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_low && !sda_low)); // R1
    AST_GO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy); // R2
    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && !scl_low && $past(in_byte && !scl_low)) |-> (sda_low == $past(sda_low))); // R5
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !scl_low && !sda_low)); // R7
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_nack && err_timeout)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> ($stable(err_nack) && $stable(err_timeout))); // R10
endmodule

bind ackpoll_writer ackpoll_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .busy        (busy),
    .done        (done),
    .err_nack    (err_nack),
    .err_timeout (err_timeout),
    .scl_low     (scl_low),
    .sda_low     (sda_low),
    .in_byte     (in_byte)
);

// File: tb/tb_ackpoll_writer.sv
`timescale 1ns/1ps
module tb_ackpoll_writer;
    localparam int DIV       = 2;
    localparam int MAXP      = 8;
    localparam int BIT_T     = 4 * DIV;

    typedef struct packed {
        logic [3:0] addr;
        logic [7:0] data;
        logic [3:0] busy_n;
        logic       ack_a;
        logic       ack_d;
        logic       e_nack;
        logic       e_to;
        logic [3:0] e_polls;
        logic       e_commit;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{4'h3, 8'hA5, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1},
        '{4'hF, 8'h3C, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 1'b1},
        '{4'h0, 8'hFF, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8, 1'b1},
        '{4'h9, 8'h00, 4'd8, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8, 1'b1},
        '{4'h5, 8'h11, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0},
        '{4'h6, 8'h22, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic scl_low, sda_low, busy, done, err_nack, err_timeout;
    logic slv_low = 1'b0;
    wire  scl = ~scl_low;
    wire  sda = ~(sda_low | slv_low);

    int tests = 0, fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ackpoll_writer #(.DIV(DIV), .MAX_POLLS(MAXP), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .addr(addr), .wdata(wdata),
        .sda_in(sda), .scl_low(scl_low), .sda_low(sda_low), .busy(busy),
        .done(done), .err_nack(err_nack), .err_timeout(err_timeout)
    );

    // Memory model
    int bitc = 0, byte_idx = 0, busy_left = 0, busy_cfg = 0;
    int starts = 0, stops = 0, commits = 0, polls = 0, bad_ctrl = 0;
    int first_start_cyc = -1, stop_cyc = 0, last_rise = 0, period_bad = 0, period_seen = 0;
    logic have_rise = 1'b0, committed = 1'b0, nacked = 1'b0, ack_a = 1'b1, ack_d = 1'b1, ack_now;
    logic [7:0] sh = '0, rx_addr = '0, rx_data = '0, cap_addr = '0, cap_data = '0;

    always @(negedge sda) if (scl === 1'b1) begin
        bitc = 0; byte_idx = 0; nacked = 1'b0; starts++;
        if (first_start_cyc < 0) first_start_cyc = cyc;
    end
    always @(posedge sda) if (scl === 1'b1) begin
        stops++; stop_cyc = cyc;
        if (byte_idx == 3 && !nacked) begin
            commits++; cap_addr = rx_addr; cap_data = rx_data;
            busy_left = busy_cfg; committed = 1'b1;
        end
    end
    always @(posedge scl) begin
        if (have_rise && bitc >= 1 && bitc <= 8) begin
            period_seen++;
            if (cyc - last_rise != BIT_T) period_bad++;
        end
        last_rise = cyc; have_rise = 1'b1;
        if (bitc < 8) begin sh = {sh[6:0], sda}; bitc++; end
    end
    always @(negedge scl) begin
        if (bitc == 8) begin
            bitc = 9;
            ack_now = 1'b0;
            case (byte_idx)
                0: begin
                    if (sh != 8'hA0) bad_ctrl++;
                    if (committed) polls++;
                    ack_now = (busy_left == 0);
                    if (!ack_now) busy_left--;
                end
                1: begin rx_addr = sh; ack_now = ack_a; end
                2: begin rx_data = sh; ack_now = ack_d; end
                default: ack_now = 1'b0;
            endcase
            if (!ack_now) nacked = 1'b1;
            slv_low = ack_now;
        end else if (bitc == 9) begin
            slv_low = 1'b0; bitc = 0; byte_idx++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    int go_cyc = 0, done_cyc = 0;
    logic done_seen;

    task automatic prep(input int bn, input logic aa, input logic ad);
        busy_cfg = bn; ack_a = aa; ack_d = ad;
        committed = 1'b0; polls = 0; stops = 0; commits = 0; bad_ctrl = 0;
        first_start_cyc = -1; period_bad = 0; period_seen = 0; have_rise = 1'b0;
    endtask

    task automatic pulse_go(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; go = 1'b1; go_cyc = cyc;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done();
        done_seen = 1'b0;
        for (int i = 0; i < 20000 && !done_seen; i++) begin
            @(negedge clk);
            if (done) begin done_seen = 1'b1; done_cyc = cyc; end
        end
    endtask

    initial begin
        repeat (20000 * 8) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 scl", scl_low, 0);
        chk("R1 sda", sda_low, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 errs", {err_nack, err_timeout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after release", {busy, scl_low, sda_low}, 0);

        for (int v = 0; v < 6; v++) begin
            prep(VECS[v].busy_n, VECS[v].ack_a, VECS[v].ack_d);
            pulse_go(VECS[v].addr, VECS[v].data);
            chk("R2 busy after go", busy, 1);
            wait_done();
            chk("R7 done seen", done_seen, 1);
            chk("R8 err_nack", err_nack, VECS[v].e_nack);
            chk("R9 err_timeout", err_timeout, VECS[v].e_to);
            chk("R6 poll count", polls, VECS[v].e_polls);
            chk("R4 commit", commits, VECS[v].e_commit);
            chk("R6 stop count", stops, 32'(VECS[v].e_polls) + 1);
            chk("R4 control bytes", bad_ctrl, 0);
            if (VECS[v].e_commit) begin
                chk("R4 addr byte", cap_addr, {4'h0, VECS[v].addr});
                chk("R4 data byte", cap_data, VECS[v].data);
            end
            chk("R3 lead gap", (first_start_cyc - go_cyc) >= BIT_T, 1);
            chk("R3 trail gap", (done_cyc - stop_cyc) >= BIT_T, 1);
            chk("R5 scl period", period_bad, 0);
            chk("R5 periods seen", period_seen > 0, 1);
            @(negedge clk);
            chk("R10 done pulse", done, 0);
            repeat (5) @(negedge clk);
            chk("R10 errors held", {err_nack, err_timeout}, {VECS[v].e_nack, VECS[v].e_to});
            chk("R1 idle lines", {busy, scl_low, sda_low}, 0);
        end

        // R2: go while busy is ignored
        prep(2, 1'b1, 1'b1);
        pulse_go(4'hA, 8'h5A);
        repeat (60) @(negedge clk);
        pulse_go(4'h1, 8'h77);
        wait_done();
        chk("R2 done", done_seen, 1);
        chk("R2 single commit", commits, 1);
        chk("R2 addr kept", cap_addr, 8'h0A);
        chk("R2 data kept", cap_data, 8'h5A);
        repeat (100) @(negedge clk);
        chk("R2 no second transfer", {busy, commits[7:0]}, {1'b0, 8'd1});

        // R10: a new go clears a held error
        prep(0, 1'b1, 1'b1);
        pulse_go(4'h2, 8'hC3);
        chk("R10 errors cleared on go", {err_nack, err_timeout}, 0);
        wait_done();
        chk("R7 clean finish", {done_seen, err_nack, err_timeout}, 3'b100);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule